// File: doc/BRIEF.md
# Configuration Access Downstream Translator

This block sits on the downstream path of a bridge between a primary and a secondary parallel bus. In each address phase it looks at the primary address word and the command. It then decides whether a hierarchical (Type 1) configuration access is aimed at a device that sits directly on the secondary bus. When it is, the block claims the access and builds the flat (Type 0) address for the secondary side. In that address the device number becomes a one-hot device-select field across the top sixteen address bits. The function and register fields are kept, and the type and device fields are cleared.

Translation runs in one direction only: a Type 0 access is only ever produced toward the secondary bus. Device numbers that have no select line give an empty select field. The highest device number, paired with a zero register field, becomes a request to issue a special cycle, and the secondary command is rewritten to the special-cycle code. All results are registered on the clock edge that samples the address-phase strobe. They are then presented with a one-cycle valid pulse.

Top module: `cfg_type1_xlat`

## Requirements
- R1: A synchronous active-high reset drives valid, claim and the special-cycle flag low on the next clock edge.
- R2: The access is claimed only when all three hold: address bits [1:0] equal 01b, address bits [23:16] equal the secondary bus number input, and the command is 1010b (configuration read) or 1011b (configuration write).
- R3: Valid is high in exactly the cycle after each edge that samples the strobe high. Claim is low whenever valid is low.
- R4: In every claimed output address, bits [1:0] and bits [15:11] are zero.
- R5: Output bits [10:2] (function and register number) equal input bits [10:2] of the claimed access.
- R6: For device numbers 0 to 15, taken from input bits [15:11], output bit 16+n is high and the other bits of [31:16] are low.
- R7: For device numbers 16 through 30, output bits [31:16] are all zero.
- R8: Device 31 with input bits [7:2] all zero raises the special-cycle flag, drives output [31:16] to zero, and sets the output command to 0001b.
- R9: Device 31 with any of input bits [7:2] set raises no special-cycle flag, gives a zero select field, and copies the command.
- R10: For a claimed access that is not a special cycle, the output command equals the input command.
- R11: When an access is not claimed, valid is still given, and the output address, command and special-cycle flag are all zero.
- R12: Input address bits [31:24] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_phase_i | input | 1 | Address-phase strobe from the primary side |
| pri_addr_i | input | 32 | Primary address word of the address phase |
| pri_cmd_i | input | 4 | Primary bus command |
| sec_bus_i | input | 8 | Secondary bus number register value |
| claim_o | output | 1 | Access is translated and claimed |
| xl_addr_o | output | 32 | Translated secondary address |
| xl_cmd_o | output | 4 | Secondary command |
| spc_req_o | output | 1 | Special-cycle generation request |
| valid_o | output | 1 | Result valid, one cycle per strobe |

## Verification
The bench targets the boundaries of the device-number decode: devices 15 and 16, device 30, and device 31 with and without a zero register field. A decoder off by one there would light a select line that does not exist, or would miss a special cycle. Each claim condition is broken on its own (type bits 00b and 11b, a neighbouring bus number, a command that differs in one bit). A loose match would show up as a claim on a foreign access. Junk in the upper address bits and back-to-back strobes expose an address builder that leaks reserved bits or a valid that stretches past one cycle.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;

  localparam logic [1:0] TYPE1_TAG   = 2'b01;
  localparam logic [2:0] CFG_CMD_HI  = 3'b101;
  localparam logic [3:0] SPECIAL_CMD = 4'b0001;

  typedef enum logic [1:0] {
    DEV_SELECT  = 2'd0,
    DEV_NONE    = 2'd1,
    DEV_SPECIAL = 2'd2
  } dev_class_e;

endpackage

// File: rtl/cfg_xlat_match.sv
module cfg_xlat_match #(
  parameter int BUS_W = 8,
  parameter int CMD_W = 4
) (
  input  logic [1:0]       type_tag_i,
  input  logic [BUS_W-1:0] bus_field_i,
  input  logic [BUS_W-1:0] sec_bus_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             hit_o
);
  import cfg_xlat_pkg::*;

  logic tag_ok;
  logic bus_ok;
  logic cmd_ok;

  always_comb begin
    tag_ok = (type_tag_i == TYPE1_TAG);
    bus_ok = (bus_field_i == sec_bus_i);
    cmd_ok = (cmd_i[CMD_W-1:1] == CFG_CMD_HI);
    hit_o  = tag_ok && bus_ok && cmd_ok;
  end

endmodule

// File: rtl/cfg_xlat_devsel.sv
module cfg_xlat_devsel #(
  parameter int DEV_W = 5,
  parameter int SEL_W = 16,
  parameter int REG_W = 6
) (
  input  logic [DEV_W-1:0]       dev_i,
  input  logic [REG_W-1:0]       reg_i,
  output logic [SEL_W-1:0]       sel_o,
  output cfg_xlat_pkg::dev_class_e cls_o
);
  import cfg_xlat_pkg::*;

  localparam logic [DEV_W-1:0] DEV_TOP = {DEV_W{1'b1}};

  for (genvar i = 0; i < SEL_W; i++) begin : g_line
    assign sel_o[i] = (dev_i == DEV_W'(i));
  end

  always_comb begin
    if (dev_i == DEV_TOP && reg_i == '0) begin
      cls_o = DEV_SPECIAL;
    end else if (sel_o != '0) begin
      cls_o = DEV_SELECT;
    end else begin
      cls_o = DEV_NONE;
    end
  end

endmodule

// File: rtl/cfg_xlat_addr.sv
module cfg_xlat_addr #(
  parameter int AD_W  = 32,
  parameter int SEL_W = 16,
  parameter int DEV_W = 5,
  parameter int FR_W  = 9
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [FR_W-1:0]  fr_i,
  output logic [AD_W-1:0]  addr_o
);

  always_comb begin
    addr_o = {sel_i, {DEV_W{1'b0}}, fr_i, 2'b00};
  end

endmodule

// File: rtl/cfg_type1_xlat.sv
module cfg_type1_xlat #(
  parameter int AD_W  = 32,
  parameter int CMD_W = 4,
  parameter int BUS_W = 8,
  parameter int DEV_W = 5,
  parameter int SEL_W = 16,
  parameter int REG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_phase_i,
  input  logic [AD_W-1:0]  pri_addr_i,
  input  logic [CMD_W-1:0] pri_cmd_i,
  input  logic [BUS_W-1:0] sec_bus_i,
  output logic             claim_o,
  output logic [AD_W-1:0]  xl_addr_o,
  output logic [CMD_W-1:0] xl_cmd_o,
  output logic             spc_req_o,
  output logic             valid_o
);
  import cfg_xlat_pkg::*;

  localparam int SEL_LSB = AD_W - SEL_W;
  localparam int DEV_LSB = SEL_LSB - DEV_W;
  localparam int FR_W    = DEV_LSB - 2;
  localparam int BUS_TOP = SEL_LSB + BUS_W;

  logic             hit;
  logic [SEL_W-1:0] sel;
  dev_class_e       cls;
  logic [AD_W-1:0]  built_addr;
  logic             unused_hi;

  assign unused_hi = ^pri_addr_i[AD_W-1:BUS_TOP];

  cfg_xlat_match #(.BUS_W(BUS_W), .CMD_W(CMD_W)) u_match (
    .type_tag_i  (pri_addr_i[1:0]),
    .bus_field_i (pri_addr_i[BUS_TOP-1:SEL_LSB]),
    .sec_bus_i   (sec_bus_i),
    .cmd_i       (pri_cmd_i),
    .hit_o       (hit)
  );

  cfg_xlat_devsel #(.DEV_W(DEV_W), .SEL_W(SEL_W), .REG_W(REG_W)) u_devsel (
    .dev_i (pri_addr_i[SEL_LSB-1:DEV_LSB]),
    .reg_i (pri_addr_i[REG_W+1:2]),
    .sel_o (sel),
    .cls_o (cls)
  );

  cfg_xlat_addr #(.AD_W(AD_W), .SEL_W(SEL_W), .DEV_W(DEV_W), .FR_W(FR_W)) u_addr (
    .sel_i  (sel),
    .fr_i   (pri_addr_i[DEV_LSB-1:2]),
    .addr_o (built_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      claim_o   <= 1'b0;
      spc_req_o <= 1'b0;
      xl_addr_o <= '0;
      xl_cmd_o  <= '0;
    end else begin
      valid_o <= addr_phase_i;
      if (addr_phase_i && hit) begin
        claim_o   <= 1'b1;
        xl_addr_o <= built_addr;
        spc_req_o <= (cls == DEV_SPECIAL);
        xl_cmd_o  <= (cls == DEV_SPECIAL) ? CMD_W'(SPECIAL_CMD) : pri_cmd_i;
      end else begin
        claim_o   <= 1'b0;
        spc_req_o <= 1'b0;
        xl_addr_o <= '0;
        xl_cmd_o  <= '0;
      end
    end
  end

endmodule

// File: rtl/cfg_type1_xlat_chk.sv
module cfg_type1_xlat_chk #(
  parameter int AD_W  = 32,
  parameter int CMD_W = 4,
  parameter int BUS_W = 8,
  parameter int SEL_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    addr_phase_i,
  input logic [AD_W-SEL_W+BUS_W-1:0] low_addr_i,
  input logic [CMD_W-1:0]        pri_cmd_i,
  input logic [BUS_W-1:0]        sec_bus_i,
  input logic                    claim_o,
  input logic [AD_W-1:0]         xl_addr_o,
  input logic [CMD_W-1:0]        xl_cmd_o,
  input logic                    spc_req_o,
  input logic                    valid_o
);
  localparam int SEL_LSB = AD_W - SEL_W;

  logic fit;
  assign fit = addr_phase_i && low_addr_i[1:0] == 2'b01 &&
               low_addr_i[SEL_LSB+BUS_W-1:SEL_LSB] == sec_bus_i &&
               pri_cmd_i[CMD_W-1:1] == 3'b101;

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!valid_o && !claim_o && !spc_req_o));

  p_claim_when_fit_r2: assert property (@(posedge clk) disable iff (rst)
    fit |=> claim_o);

  p_no_claim_unfit_r2: assert property (@(posedge clk) disable iff (rst)
    !fit |=> !claim_o);

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    addr_phase_i |=> valid_o);

  p_valid_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !addr_phase_i |=> !valid_o);

  p_zero_fields_r4: assert property (@(posedge clk) disable iff (rst)
    claim_o |-> (xl_addr_o[1:0] == 2'b00 && xl_addr_o[SEL_LSB-1:SEL_LSB-5] == '0));

  p_func_reg_pass_r5: assert property (@(posedge clk) disable iff (rst)
    fit |=> xl_addr_o[SEL_LSB-6:2] == $past(low_addr_i[SEL_LSB-6:2]));

  p_select_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $onehot0(xl_addr_o[AD_W-1:SEL_LSB]));

  p_special_shape_r8: assert property (@(posedge clk) disable iff (rst)
    spc_req_o |-> (claim_o && xl_addr_o[AD_W-1:SEL_LSB] == '0 && xl_cmd_o == 4'b0001));

  p_unclaimed_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !claim_o |-> (xl_addr_o == '0 && xl_cmd_o == '0 && !spc_req_o));

endmodule

bind cfg_type1_xlat cfg_type1_xlat_chk #(
  .AD_W(AD_W), .CMD_W(CMD_W), .BUS_W(BUS_W), .SEL_W(SEL_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .addr_phase_i (addr_phase_i),
  .low_addr_i   (pri_addr_i[AD_W-SEL_W+BUS_W-1:0]),
  .pri_cmd_i    (pri_cmd_i),
  .sec_bus_i    (sec_bus_i),
  .claim_o      (claim_o),
  .xl_addr_o    (xl_addr_o),
  .xl_cmd_o     (xl_cmd_o),
  .spc_req_o    (spc_req_o),
  .valid_o      (valid_o)
);

// File: tb/cfg_type1_xlat_bench.sv
`timescale 1ns/1ps
module cfg_type1_xlat_bench;

  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst;
  logic        addr_phase_i;
  logic [31:0] pri_addr_i;
  logic [3:0]  pri_cmd_i;
  logic [7:0]  sec_bus_i;
  logic        claim_o;
  logic [31:0] xl_addr_o;
  logic [3:0]  xl_cmd_o;
  logic        spc_req_o;
  logic        valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(HALF) clk = ~clk;

  cfg_type1_xlat u_cfg_type1_xlat (
    .clk(clk), .rst(rst), .addr_phase_i(addr_phase_i),
    .pri_addr_i(pri_addr_i), .pri_cmd_i(pri_cmd_i), .sec_bus_i(sec_bus_i),
    .claim_o(claim_o), .xl_addr_o(xl_addr_o), .xl_cmd_o(xl_cmd_o),
    .spc_req_o(spc_req_o), .valid_o(valid_o)
  );

  // addr, cmd, exp_claim, exp_addr, exp_cmd, exp_spc ; bus register 3Ch
  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  cmd;
    logic        claim;
    logic [31:0] xaddr;
    logic [3:0]  xcmd;
    logic        spc;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h003C0001, 4'hA, 1'b1, 32'h00010000, 4'hA, 1'b0}, // R6 dev0
    '{32'h003C2B45, 4'hB, 1'b1, 32'h00200344, 4'hB, 1'b0}, // R5 R6 R10 dev5
    '{32'hFF3C7FFD, 4'hA, 1'b1, 32'h800007FC, 4'hA, 1'b0}, // R12 R6 dev15
    '{32'h003C8109, 4'hA, 1'b1, 32'h00000108, 4'hA, 1'b0}, // R7 dev16
    '{32'h003CF005, 4'hB, 1'b1, 32'h00000004, 4'hB, 1'b0}, // R7 dev30
    '{32'h003CFA01, 4'hB, 1'b1, 32'h00000200, 4'h1, 1'b1}, // R8 special
    '{32'h003CF805, 4'hA, 1'b1, 32'h00000004, 4'hA, 1'b0}, // R9 dev31 reg1
    '{32'h003C0800, 4'hA, 1'b0, 32'h00000000, 4'h0, 1'b0}, // R2 type 00
    '{32'h003C0803, 4'hA, 1'b0, 32'h00000000, 4'h0, 1'b0}, // R2 type 11
    '{32'h003D0801, 4'hA, 1'b0, 32'h00000000, 4'h0, 1'b0}, // R2 bus off
    '{32'h003C0801, 4'h2, 1'b0, 32'h00000000, 4'h0, 1'b0}, // R2 cmd off
    '{32'h003C4081, 4'hB, 1'b1, 32'h01000080, 4'hB, 1'b0}, // R6 dev8
    '{32'h003C0801, 4'hE, 1'b0, 32'h00000000, 4'h0, 1'b0}  // R11 cmd 1110
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [3:0] c, input logic [7:0] b);
    @(negedge clk);
    pri_addr_i = a; pri_cmd_i = c; sec_bus_i = b; addr_phase_i = 1'b1;
    @(negedge clk);
    addr_phase_i = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; addr_phase_i = 1'b0; pri_addr_i = '0; pri_cmd_i = '0; sec_bus_i = 8'h3C;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'd0, valid_o}, 32'd0);
    check("R1 claim", {31'd0, claim_o}, 32'd0);
    check("R1 special", {31'd0, spc_req_o}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].addr, VECS[i].cmd, 8'h3C);
      check("R3 valid", {31'd0, valid_o}, 32'd1);
      check("R2 claim", {31'd0, claim_o}, {31'd0, VECS[i].claim});
      check("R4 R5 R6 R7 addr", xl_addr_o, VECS[i].xaddr);
      check("R8 R10 cmd", {28'd0, xl_cmd_o}, {28'd0, VECS[i].xcmd});
      check("R8 R9 special", {31'd0, spc_req_o}, {31'd0, VECS[i].spc});
    end

    // R3: valid and claim drop the cycle after the strobe is gone
    @(negedge clk);
    check("R3 valid idle", {31'd0, valid_o}, 32'd0);
    check("R3 claim idle", {31'd0, claim_o}, 32'd0);

    // R6 R7 R8: sweep every device number, expectation built from the rules
    for (int d = 0; d < 32; d++) begin
      logic [31:0] a;
      logic [31:0] e;
      a = {8'h5A, 8'h77, d[4:0], 3'd6, 6'd0, 2'b01};
      e = (d < 16) ? (32'd1 << (16 + d)) : 32'd0;
      e = e | {21'd0, 3'd6, 6'd0, 2'b00};
      issue(a, 4'hB, 8'h77);
      check("R6 R7 sweep addr", xl_addr_o, e);
      check("R8 sweep special", {31'd0, spc_req_o}, {31'd0, (d == 31)});
      check("R10 sweep cmd", {28'd0, xl_cmd_o}, (d == 31) ? 32'd1 : 32'hB);
    end

    // R2: bus register change flips claim for the same access
    issue(32'h00770801, 4'hA, 8'h78);
    check("R2 bus register", {31'd0, claim_o}, 32'd0);
    check("R11 quiet addr", xl_addr_o, 32'd0);

    // R3: back-to-back strobes keep valid high each cycle
    @(negedge clk);
    pri_addr_i = 32'h003C0801; pri_cmd_i = 4'hA; sec_bus_i = 8'h3C; addr_phase_i = 1'b1;
    @(negedge clk);
    check("R3 b2b first", {31'd0, valid_o}, 32'd1);
    pri_addr_i = 32'h003C1001;
    @(negedge clk);
    addr_phase_i = 1'b0;
    check("R3 b2b second", {31'd0, valid_o}, 32'd1);
    check("R6 b2b addr", xl_addr_o, 32'h00040000);

    // R1: reset in the middle of a result clears it
    @(negedge clk);
    pri_addr_i = 32'h003C0801; addr_phase_i = 1'b1;
    @(negedge clk);
    addr_phase_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1 mid valid", {31'd0, valid_o}, 32'd0);
    check("R1 mid claim", {31'd0, claim_o}, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule